// File: doc/BRIEF.md
# Dot-clock sync timing generator

This block produces the horizontal sync, vertical sync, data-enable and pixel-request signals for a parallel RGB panel driven on a pixel clock. The geometry arrives as static programmed values: the line period in pixel clocks, the hsync pulse width, a horizontal wait count and a horizontal valid count, the frame period in lines, the vsync pulse width in lines, a vertical wait count and a vertical valid count. Both wait counts are taken from the leading edge of their sync pulse to the first active pixel or line, so the active window is placed without separate porch values.

A horizontal counter runs across each line and a vertical counter steps once per line. Pulse and window decodes from the two counters pass through one output register, then through per-signal polarity selection. A one-cycle frame-start strobe marks the first pixel clock of every frame for the scan address logic. A sync-enable input starts the sync outputs and a run input starts data transfer. Run has no effect until the syncs are going, and the syncs keep going after sync-enable drops for as long as run stays high.

A build parameter selects an older variant in which only the low 8 bits of the hsync width are used.

Top module: `dotclk_sync_gen`

## Requirements
- R1: During reset, and in the first cycle after it, hsync, vsync and data_en sit at their inactive levels, and pix_req and frame_start are 0.
- R2: Once started, the output in the n-th cycle after the first clock edge with sync_en high shows counter position n. The horizontal position is n mod h_period. hsync is active while the horizontal position is below h_pulse.
- R3: The line number is (n div h_period) mod v_period. vsync is active while the line number is below v_pulse.
- R4: pix_req is 1 and data_en is active only when three conditions hold together: the horizontal position is in [h_wait, h_wait+h_valid), the line is in [v_wait, v_wait+v_valid), and run is high.
- R5: hsync, vsync and data_en are each active high when their polarity input (hs_act_high, vs_act_high, de_act_high) is 1, and active low when it is 0.
- R6: frame_start is 1 for exactly one cycle, at horizontal position 0 of line 0 of every frame, and 0 otherwise.
- R7: When sync_en and run are both low at a clock edge, every output is inactive in the next cycle. The next start begins again at position 0.
- R8: A high run with sync_en low and the syncs not already going is ignored. All outputs stay inactive.
- R9: If sync_en drops while run is high, the syncs and the data window continue without a break. They stop in the cycle after the first edge at which run is also low.
- R10: With de_present at 0, data_en stays inactive while pix_req still follows R4.
- R11: With the legacy variant selected (HPW_LEGACY=1), only bits [7:0] of h_pulse set the hsync width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_en | input | 1 | Starts the sync outputs |
| run | input | 1 | Starts data transfer once the syncs are going |
| h_period | input | 18 | Pixel clocks per line |
| h_pulse | input | 14 | Hsync width in pixel clocks |
| h_wait | input | 12 | Pixel clocks from hsync start to the first active pixel |
| h_valid | input | 18 | Active pixels per line |
| v_period | input | 16 | Lines per frame |
| v_pulse | input | 18 | Vsync width in lines |
| v_wait | input | 16 | Lines from vsync start to the first active line |
| v_valid | input | 16 | Active lines per frame |
| hs_act_high | input | 1 | Hsync active level is high |
| vs_act_high | input | 1 | Vsync active level is high |
| de_act_high | input | 1 | Data enable active level is high |
| de_present | input | 1 | Drives the data-enable output |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| data_en | output | 1 | Data enable |
| pix_req | output | 1 | Active-high pixel request strobe |
| frame_start | output | 1 | One-cycle pulse at the first pixel clock of a frame |

## Verification
On every cycle the assertions check the counter stepping and wrap, the return to position zero when the block is idle, the fact that data enable never appears without a pixel request, the frame origin following the last position of a frame, and the absence of pixel requests before the syncs start. Only the bench scenarios can show the exact placement of the sync pulses and the active window for given programmed values, the polarity levels and the enable and disable ordering. The same holds for the de_present masking and the legacy width truncation, all of which the bench checks against an arithmetic model of the position.

// File: rtl/dsg_pkg.sv
package dsg_pkg;
   // Active-high decoded timing bits carried through the output register
   typedef struct packed {
      logic hs;
      logic vs;
      logic de;
      logic req;
      logic fs;
   } dsg_bits_t;

   function automatic int dsg_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/dsg_axis.sv
// One timing axis: counter with wrap, sync pulse decode and active window decode
module dsg_axis #(
   parameter int CNT_W  = 18,
   parameter int PW_W   = 14,
   parameter int WAIT_W = 12,
   parameter int VAL_W  = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              live,
   input  logic              step,
   input  logic [CNT_W-1:0]  period,
   input  logic [PW_W-1:0]   pulse,
   input  logic [WAIT_W-1:0] wait_cnt,
   input  logic [VAL_W-1:0]  valid,
   output logic [CNT_W-1:0]  cnt,
   output logic              wrap,
   output logic              at_zero,
   output logic              in_pulse,
   output logic              in_window
);
   localparam int MW = dsg_pkg::dsg_max(dsg_pkg::dsg_max(CNT_W, PW_W),
                                        dsg_pkg::dsg_max(WAIT_W, VAL_W)) + 1;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("dsg_axis: CNT_W must be at least 2");
      end
      if (WAIT_W > CNT_W) begin : g_bad_wait
         $error("dsg_axis: WAIT_W must not exceed CNT_W");
      end
   endgenerate

   logic [MW-1:0] cnt_x, per_x, pw_x, wait_x, val_x, next_x, ofs_x;

   assign cnt_x  = MW'(cnt);
   assign per_x  = MW'(period);
   assign pw_x   = MW'(pulse);
   assign wait_x = MW'(wait_cnt);
   assign val_x  = MW'(valid);
   assign next_x = cnt_x + 1'b1;
   assign ofs_x  = cnt_x - wait_x;

   // A period of 0 or 1 keeps the counter at zero
   assign wrap      = (next_x >= per_x);
   assign at_zero   = (cnt == '0);
   assign in_pulse  = (cnt_x < pw_x);
   assign in_window = (cnt_x >= wait_x) && (ofs_x < val_x);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!live)   cnt <= '0;
      else if (step)    cnt <= wrap ? '0 : cnt + 1'b1;
   end

   a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (live && step && wrap) |=> (cnt == '0));
   a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      (live && step && !wrap) |=> (cnt == $past(cnt) + 1'b1));
   a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!live) |=> (cnt == '0));
endmodule

// File: rtl/dsg_out_stage.sv
// Output register plus per-signal polarity selection
module dsg_out_stage (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              live,
   input  dsg_pkg::dsg_bits_t d,
   input  logic              hs_act_high,
   input  logic              vs_act_high,
   input  logic              de_act_high,
   output logic              hsync,
   output logic              vsync,
   output logic              data_en,
   output logic              pix_req,
   output logic              frame_start
);
   dsg_pkg::dsg_bits_t q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (!live) q <= '0;
      else            q <= d;
   end

   // Active-high state kept in the register; the level follows the polarity
   assign hsync       = ~(q.hs ^ hs_act_high);
   assign vsync       = ~(q.vs ^ vs_act_high);
   assign data_en     = ~(q.de ^ de_act_high);
   assign pix_req     = q.req;
   assign frame_start = q.fs;

   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!live) |=> (q == '0));
   a_r4_de_implies_req: assert property (@(posedge clk) disable iff (!rst_n)
      q.de |-> q.req);
endmodule

// File: rtl/dotclk_sync_gen.sv
module dotclk_sync_gen #(
   parameter int HP_W        = 18,
   parameter int HPW_W       = 14,
   parameter int HW_W        = 12,
   parameter int HV_W        = 18,
   parameter int VP_W        = 16,
   parameter int VPW_W       = 18,
   parameter int VW_W        = 16,
   parameter int VV_W        = 16,
   parameter bit HPW_LEGACY  = 1'b0,
   parameter int LEGACY_PW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_en,
   input  logic             run,
   input  logic [HP_W-1:0]  h_period,
   input  logic [HPW_W-1:0] h_pulse,
   input  logic [HW_W-1:0]  h_wait,
   input  logic [HV_W-1:0]  h_valid,
   input  logic [VP_W-1:0]  v_period,
   input  logic [VPW_W-1:0] v_pulse,
   input  logic [VW_W-1:0]  v_wait,
   input  logic [VV_W-1:0]  v_valid,
   input  logic             hs_act_high,
   input  logic             vs_act_high,
   input  logic             de_act_high,
   input  logic             de_present,
   output logic             hsync,
   output logic             vsync,
   output logic             data_en,
   output logic             pix_req,
   output logic             frame_start
);
   // Sync-on state: started by sync_en, held by run until run drops
   logic live_q, live, run_eff;

   assign live    = sync_en | (run & live_q);
   assign run_eff = run & live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= live;
   end

   // Hsync width field: full or legacy truncated
   logic [HPW_W-1:0] h_pulse_eff;

   generate
      if (HPW_LEGACY) begin : g_legacy_pw
         if (LEGACY_PW_W >= HPW_W) begin : g_bad_legacy
            $error("dotclk_sync_gen: LEGACY_PW_W must be below HPW_W");
         end
         assign h_pulse_eff = {{(HPW_W-LEGACY_PW_W){1'b0}}, h_pulse[LEGACY_PW_W-1:0]};
      end else begin : g_full_pw
         assign h_pulse_eff = h_pulse;
      end
   endgenerate

   logic [HP_W-1:0] h_cnt;
   logic [VP_W-1:0] v_cnt;
   logic h_wrap, h_zero, h_pulse_on, h_win;
   logic v_wrap, v_zero, v_pulse_on, v_win;

   dsg_axis #(.CNT_W(HP_W), .PW_W(HPW_W), .WAIT_W(HW_W), .VAL_W(HV_W)) u_h_axis (
      .clk       (clk),
      .rst_n     (rst_n),
      .live      (live),
      .step      (1'b1),
      .period    (h_period),
      .pulse     (h_pulse_eff),
      .wait_cnt  (h_wait),
      .valid     (h_valid),
      .cnt       (h_cnt),
      .wrap      (h_wrap),
      .at_zero   (h_zero),
      .in_pulse  (h_pulse_on),
      .in_window (h_win)
   );

   dsg_axis #(.CNT_W(VP_W), .PW_W(VPW_W), .WAIT_W(VW_W), .VAL_W(VV_W)) u_v_axis (
      .clk       (clk),
      .rst_n     (rst_n),
      .live      (live),
      .step      (h_wrap),
      .period    (v_period),
      .pulse     (v_pulse),
      .wait_cnt  (v_wait),
      .valid     (v_valid),
      .cnt       (v_cnt),
      .wrap      (v_wrap),
      .at_zero   (v_zero),
      .in_pulse  (v_pulse_on),
      .in_window (v_win)
   );

   dsg_pkg::dsg_bits_t dec;

   always_comb begin
      dec.hs  = h_pulse_on;
      dec.vs  = v_pulse_on;
      dec.req = run_eff & h_win & v_win;
      dec.de  = run_eff & h_win & v_win & de_present;
      dec.fs  = h_zero & v_zero;
   end

   dsg_out_stage u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .live        (live),
      .d           (dec),
      .hs_act_high (hs_act_high),
      .vs_act_high (vs_act_high),
      .de_act_high (de_act_high),
      .hsync       (hsync),
      .vsync       (vsync),
      .data_en     (data_en),
      .pix_req     (pix_req),
      .frame_start (frame_start)
   );

   // Last position of a frame leads back to the origin
   a_r6_frame_origin: assert property (@(posedge clk) disable iff (!rst_n)
      (live && h_wrap && v_wrap) |=> (h_zero && v_zero));
   // Run alone never starts a pixel request
   a_r8_req_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_en && !live_q) |=> !pix_req);
   // Vertical counter stays put between line wraps
   a_r3_line_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !h_wrap) |=> (v_cnt == $past(v_cnt)));
   // Horizontal count never reaches beyond a stable period once inside it
   a_r2_h_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (live && h_period > 1 && h_cnt < h_period && $stable(h_period)) |=> (h_cnt < h_period));
endmodule

// File: tb/dotclk_sync_gen_bench.sv
`timescale 1ns/1ps
module dotclk_sync_gen_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_en = 1'b0, run = 1'b0;
   logic [17:0] h_period = 18'd10, h_valid = 18'd4, v_pulse = 18'd1;
   logic [13:0] h_pulse = 14'd2, lg_pulse = 14'h102;
   logic [11:0] h_wait = 12'd4;
   logic [15:0] v_period = 16'd6, v_wait = 16'd2, v_valid = 16'd3;
   logic hs_pol = 1'b0, vs_pol = 1'b1, de_pol = 1'b1, de_present = 1'b1;
   logic hsync, vsync, data_en, pix_req, frame_start;
   logic lg_hsync, lg_vsync, lg_de, lg_req, lg_fs;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   dotclk_sync_gen u_dotclk_sync_gen (
      .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .run(run),
      .h_period(h_period), .h_pulse(h_pulse), .h_wait(h_wait), .h_valid(h_valid),
      .v_period(v_period), .v_pulse(v_pulse), .v_wait(v_wait), .v_valid(v_valid),
      .hs_act_high(hs_pol), .vs_act_high(vs_pol), .de_act_high(de_pol),
      .de_present(de_present),
      .hsync(hsync), .vsync(vsync), .data_en(data_en), .pix_req(pix_req),
      .frame_start(frame_start));

   dotclk_sync_gen #(.HPW_LEGACY(1'b1)) u_legacy (
      .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .run(run),
      .h_period(h_period), .h_pulse(lg_pulse), .h_wait(h_wait), .h_valid(h_valid),
      .v_period(v_period), .v_pulse(v_pulse), .v_wait(v_wait), .v_valid(v_valid),
      .hs_act_high(hs_pol), .vs_act_high(vs_pol), .de_act_high(de_pol),
      .de_present(de_present),
      .hsync(lg_hsync), .vsync(lg_vsync), .data_en(lg_de), .pix_req(lg_req),
      .frame_start(lg_fs));

   task automatic check_bit(input string req, input string ctx, input string nm,
                            input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s %s actual=%0b expected=%0b", req, ctx, nm, act, exp);
      end
   endtask

   // All outputs at inactive level
   task automatic check_idle(input string req);
      check_bit(req, "idle", "hsync", hsync, ~hs_pol);
      check_bit(req, "idle", "vsync", vsync, ~vs_pol);
      check_bit(req, "idle", "data_en", data_en, ~de_pol);
      check_bit(req, "idle", "pix_req", pix_req, 1'b0);
      check_bit(req, "idle", "frame_start", frame_start, 1'b0);
   endtask

   // Arithmetic model of position pos
   task automatic check_pos(input int pos, input bit run_m, input string ctx);
      int h, v;
      bit hs, vs, win, de, rq, fs;
      h   = pos % int'(h_period);
      v   = (pos / int'(h_period)) % int'(v_period);
      hs  = h < int'(h_pulse);
      vs  = v < int'(v_pulse);
      win = (h >= int'(h_wait)) && (h < int'(h_wait) + int'(h_valid)) &&
            (v >= int'(v_wait)) && (v < int'(v_wait) + int'(v_valid));
      rq  = win && run_m;
      de  = rq && de_present;
      fs  = (h == 0) && (v == 0);
      check_bit("R2", ctx, "hsync", hsync, hs_pol ? hs : !hs);
      check_bit("R3", ctx, "vsync", vsync, vs_pol ? vs : !vs);
      check_bit("R4", ctx, "data_en", data_en, de_pol ? de : !de);
      check_bit("R4", ctx, "pix_req", pix_req, rq);
      check_bit("R6", ctx, "frame_start", frame_start, fs);
      // R11: legacy variant uses only low 8 bits of its hsync width
      check_bit("R11", ctx, "legacy hsync", lg_hsync, hs_pol ? hs : !hs);
   endtask

   initial begin
      // R1: reset state
      #1;
      check_idle("R1");
      repeat (3) @(negedge clk);
      check_idle("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1");

      // Config A: R2 R3 R4 R6 R11, start with run and sync together
      hs_pol = 1'b1; vs_pol = 1'b1; de_pol = 1'b1;
      sync_en = 1'b1; run = 1'b1;
      for (int p = 0; p < 120; p++) begin
         @(negedge clk);
         check_pos(p, 1'b1, "cfgA");
      end

      // R7: stop both, next cycle idle, counters restart
      sync_en = 1'b0; run = 1'b0;
      @(negedge clk);
      check_idle("R7");
      repeat (4) @(negedge clk);

      // R8: run alone is ignored
      run = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         check_idle("R8");
      end
      run = 1'b0;
      @(negedge clk);

      // Config B, active-low polarities (R5), de_present low (R10)
      h_period = 18'd7; h_pulse = 14'd3; lg_pulse = 14'h103; h_wait = 12'd3; h_valid = 18'd3;
      v_period = 16'd5; v_pulse = 18'd2; v_wait = 16'd2; v_valid = 16'd2;
      hs_pol = 1'b0; vs_pol = 1'b0; de_pol = 1'b0; de_present = 1'b0;
      @(negedge clk);
      check_idle("R5");
      sync_en = 1'b1; run = 1'b1;
      for (int p = 0; p < 35; p++) begin
         @(negedge clk);
         check_pos(p, 1'b1, "R5 R10 cfgB");
      end
      sync_en = 1'b0; run = 1'b0;
      @(negedge clk);
      check_idle("R7");

      // R7 restart from position 0, then R9: drop sync_en with run held
      de_present = 1'b1;
      sync_en = 1'b1; run = 1'b1;
      for (int p = 0; p < 20; p++) begin
         @(negedge clk);
         check_pos(p, 1'b1, "R7 restart");
      end
      sync_en = 1'b0;
      for (int p = 20; p < 50; p++) begin
         @(negedge clk);
         check_pos(p, 1'b1, "R9 hold");
      end
      run = 1'b0;
      @(negedge clk);
      check_idle("R9");
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         check_idle("R9");
      end

      // Syncs without run: window masked (R4)
      sync_en = 1'b1;
      for (int p = 0; p < 35; p++) begin
         @(negedge clk);
         check_pos(p, 1'b0, "R4 no run");
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule